// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block sits between a processor request port and a slower main-memory port. The processor issues a byte address. The two low bits select a byte inside a 4-byte line and are ignored, because each line holds exactly one 32-bit data word. The next `IDX_W` bits pick the one line that the block may occupy. The remaining high bits form the tag that is stored with the line. A lookup that finds a valid line with a matching tag is served at once from the array. Any other access stalls the processor with `cpu_ready` low while the controller talks to memory over a simple request/acknowledge handshake.

Two runtime mode inputs set the behaviour. `mode_disable` sends every access straight to memory. `mode_wb` chooses write-back when high and write-through when low. In write-back mode, stores stay in the array and mark the line dirty. A dirty line is copied to memory only when it is displaced, or when a flush command is issued. There are two command pulses: one drops every line at once, and the other first writes every dirty line to memory and then drops them all.

The address split is parameterised. The default build keeps the array small (64 lines). An 8-bit tag and a 14-bit index over a 24-bit address is a matter of setting `IDX_W`.

Top module: `dmc_cache`

## Requirements
- R1: The line index is taken from address bits [OFS_W+IDX_W-1:OFS_W] and the tag from the bits above them. Addresses that differ only in bits [OFS_W-1:0] refer to the same line.
- R2: After reset every line is invalid, so the first access to any address goes to memory. While idle, `cpu_ready` and `mem_req` are low.
- R3: A read that hits is answered in the same cycle it is presented (`cpu_ready` high, data from the array) and raises no memory request.
- R4: A read miss issues exactly one memory read of block address `cpu_addr[ADDR_W-1:OFS_W]`, installs the returned word in the indexed line, and only then returns it. `cpu_ready` stays low until that has happened.
- R5: In write-back mode (`mode_wb`=1, `mode_disable`=0), a write updates only the array and marks the line dirty, with no memory write. A write miss first fetches the line with one memory read.
- R6: When a miss displaces a valid line, that line is written to memory at block address {old tag, index} before the fill, and only if it is dirty.
- R7: In write-through mode (`mode_wb`=0, `mode_disable`=0), every write performs exactly one memory write. A hit also updates the array. A write miss does not allocate, so a later read of that address misses.
- R8: With `mode_disable`=1, every access performs exactly one memory transfer of the same direction, and nothing is allocated in the array.
- R9: A one-cycle `cmd_inval` pulse while idle makes every line invalid with no memory traffic. Dirty data held in the array is discarded.
- R10: A one-cycle `cmd_flush` pulse while idle writes every dirty line to memory and then makes all lines invalid.
- R11: Once raised, `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_disable | input | 1 | Bypass the array for all accesses |
| mode_wb | input | 1 | 1 = write-back, 0 = write-through |
| cmd_inval | input | 1 | Pulse: invalidate all lines |
| cmd_flush | input | 1 | Pulse: write dirty lines back, then invalidate all |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | Access is a write |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Access completes at this clock edge |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory transfer is a write |
| mem_addr | output | ADDR_W-OFS_W | Memory block address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory transfer completes |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |

## Verification
The bench builds the controller with `IDX_W`=4, so it has 16 lines. Two addresses 64 bytes apart then fight over one line, and a flush scan takes only a few dozen cycles. This makes dirty and clean evictions, write-through non-allocation, bypass, and both commands easy to reach in a short run. Every access is compared against a behavioural model of the lines and of the expected memory contents: the returned word, the number of memory reads and writes, and whether a hit answers without delay.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_BYPASS = 3'd1,
    S_EVICT  = 3'd2,
    S_FILL   = 3'd3,
    S_FLUSH  = 3'd4
  } dmc_state_t;
endpackage

// File: rtl/dmc_store.sv
// Line storage: valid/dirty flags with reset, tag and data arrays without.
module dmc_store #(
  parameter int TAG_W  = 16,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_dirty,
  input  logic              inval_all,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_q, dirty_q;
  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [DATA_W-1:0] data_mem [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (inval_all) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[idx]  <= wr_tag;
      data_mem[idx] <= wr_data;
    end
  end

  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];
  assign rd_tag   = tag_mem[idx];
  assign rd_data  = data_mem[idx];
endmodule

// File: rtl/dmc_fsm.sv
// Lookup, miss handling, bypass and flush sequencing.
module dmc_fsm
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OFS_W  = 2,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32,
  localparam int TAG_W = ADDR_W - OFS_W - IDX_W,
  localparam int BLK_W = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_disable,
  input  logic              mode_wb,
  input  logic              cmd_inval,
  input  logic              cmd_flush,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [BLK_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  lk_idx,
  input  logic              lk_valid,
  input  logic              lk_dirty,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [DATA_W-1:0] lk_data,
  output logic              st_we,
  output logic [TAG_W-1:0]  st_tag,
  output logic [DATA_W-1:0] st_data,
  output logic              st_dirty,
  output logic              st_inval
);
  localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

  dmc_state_t       state_q, state_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  logic [TAG_W-1:0] cpu_tag;
  logic [IDX_W-1:0] cpu_idx;
  logic [BLK_W-1:0] cpu_blk;
  logic             hit, victim_dirty, unused_ofs;

  assign cpu_blk    = cpu_addr[ADDR_W-1:OFS_W];
  assign cpu_tag    = cpu_addr[ADDR_W-1 -: TAG_W];
  assign cpu_idx    = cpu_addr[OFS_W +: IDX_W];
  assign unused_ofs = ^cpu_addr[OFS_W-1:0];

  assign lk_idx       = (state_q == S_FLUSH) ? cnt_q : cpu_idx;
  assign hit          = lk_valid && (lk_tag == cpu_tag);
  assign victim_dirty = lk_valid && lk_dirty;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    cnt_en    = 1'b0;
    cpu_ready = 1'b0;
    cpu_rdata = lk_data;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cpu_blk;
    mem_wdata = cpu_wdata;
    st_we     = 1'b0;
    st_tag    = cpu_tag;
    st_data   = cpu_wdata;
    st_dirty  = 1'b0;
    st_inval  = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (cmd_inval) begin
          st_inval = 1'b1;
        end else if (cmd_flush) begin
          state_d = S_FLUSH;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end else if (cpu_req) begin
          if (mode_disable) begin
            state_d = S_BYPASS;
          end else if (hit) begin
            if (!cpu_we) begin
              cpu_ready = 1'b1;
            end else if (mode_wb) begin
              st_we     = 1'b1;
              st_dirty  = 1'b1;
              cpu_ready = 1'b1;
            end else begin
              state_d = S_BYPASS;
            end
          end else if (cpu_we && !mode_wb) begin
            state_d = S_BYPASS;
          end else if (victim_dirty) begin
            state_d = S_EVICT;
          end else begin
            state_d = S_FILL;
          end
        end
      end
      S_BYPASS: begin
        mem_req = 1'b1;
        mem_we  = cpu_we;
        if (mem_ack) begin
          cpu_ready = 1'b1;
          cpu_rdata = mem_rdata;
          state_d   = S_IDLE;
          if (cpu_we && !mode_disable && hit) begin
            st_we    = 1'b1;
            st_dirty = lk_dirty;
          end
        end
      end
      S_EVICT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {lk_tag, lk_idx};
        mem_wdata = lk_data;
        if (mem_ack) state_d = S_FILL;
      end
      S_FILL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          st_we   = 1'b1;
          st_data = mem_rdata;
          state_d = S_IDLE;
        end
      end
      S_FLUSH: begin
        mem_addr  = {lk_tag, lk_idx};
        mem_wdata = lk_data;
        mem_req   = victim_dirty;
        mem_we    = victim_dirty;
        if (!victim_dirty || mem_ack) begin
          if (mem_ack) begin
            st_we   = 1'b1;
            st_tag  = lk_tag;
            st_data = lk_data;
          end
          if (cnt_q == LAST_IDX) begin
            st_inval = 1'b1;
            state_d  = S_IDLE;
          end else begin
            cnt_d  = cnt_q + 1'b1;
            cnt_en = 1'b1;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
  parameter int ADDR_W = 24,
  parameter int OFS_W  = 2,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32,
  localparam int TAG_W = ADDR_W - OFS_W - IDX_W,
  localparam int BLK_W = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_disable,
  input  logic              mode_wb,
  input  logic              cmd_inval,
  input  logic              cmd_flush,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [BLK_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic [IDX_W-1:0]  lk_idx;
  logic              lk_valid, lk_dirty, st_we, st_dirty, st_inval;
  logic [TAG_W-1:0]  lk_tag, st_tag;
  logic [DATA_W-1:0] lk_data, st_data;

  // Asserted asynchronously, released on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  dmc_fsm #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_core_n),
    .mode_disable(mode_disable), .mode_wb(mode_wb),
    .cmd_inval(cmd_inval), .cmd_flush(cmd_flush),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_dirty(lk_dirty),
    .lk_tag(lk_tag), .lk_data(lk_data),
    .st_we(st_we), .st_tag(st_tag), .st_data(st_data),
    .st_dirty(st_dirty), .st_inval(st_inval)
  );

  dmc_store #(
    .TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rst_n(rst_core_n), .idx(lk_idx),
    .wr_en(st_we), .wr_tag(st_tag), .wr_data(st_data), .wr_dirty(st_dirty),
    .inval_all(st_inval),
    .rd_valid(lk_valid), .rd_dirty(lk_dirty), .rd_tag(lk_tag), .rd_data(lk_data)
  );
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
  parameter int ADDR_W = 24,
  parameter int OFS_W  = 2,
  parameter int DATA_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    mode_disable,
  input logic                    mode_wb,
  input logic                    cpu_req,
  input logic                    cpu_we,
  input logic                    cpu_ready,
  input logic                    mem_req,
  input logic                    mem_we,
  input logic [ADDR_W-OFS_W-1:0] mem_addr,
  input logic [DATA_W-1:0]       mem_wdata,
  input logic                    mem_ack
);
  // R3 / R4: the processor is released only with no memory transfer open
  a_r3_ready_no_open_mem: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> (!mem_req || mem_ack));

  // R5: a completed write in write-back mode raises no memory request
  a_r5_wb_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && cpu_ready && mode_wb && !mode_disable) |-> !mem_req);

  // R7: a completed write in write-through mode coincides with a memory write
  a_r7_wt_write_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && cpu_ready && !mode_wb && !mode_disable)
      |-> (mem_req && mem_we && mem_ack));

  // R8: in bypass every completed access is a memory transfer of the same direction
  a_r8_bypass_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_ready && mode_disable) |-> (mem_req && mem_ack && (mem_we == cpu_we)));

  // R11: an open memory request holds its fields until acknowledged
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));
endmodule

bind dmc_cache dmc_checker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_disable(mode_disable), .mode_wb(mode_wb),
  .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_ready(cpu_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/tb_dmc_cache.sv
`timescale 1ns/1ps
module tb_dmc_cache;
  localparam int ADDR_W = 24;
  localparam int OFS_W  = 2;
  localparam int IDX_W  = 4;
  localparam int DATA_W = 32;
  localparam int LINES  = 1 << IDX_W;
  localparam int BLK_W  = ADDR_W - OFS_W;
  localparam int MEM_LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_disable = 1'b0, mode_wb = 1'b1, cmd_inval = 1'b0, cmd_flush = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic cpu_ready, mem_req, mem_we;
  logic [DATA_W-1:0] cpu_rdata, mem_wdata;
  logic [BLK_W-1:0] mem_addr;
  logic mem_ack = 1'b0;
  logic [DATA_W-1:0] mem_rdata = '0;

  always #2 clk = ~clk;

  dmc_cache #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .mode_disable(mode_disable), .mode_wb(mode_wb),
    .cmd_inval(cmd_inval), .cmd_flush(cmd_flush),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  int tests = 0, fails = 0, nrd = 0, nwr = 0, wcnt = 0;
  bit done = 1'b0;

  // Backing memory seen by the design, and the expected memory from the model.
  logic [DATA_W-1:0] mem [int];
  logic [DATA_W-1:0] bs  [int];
  bit                m_v [LINES];
  bit                m_d [LINES];
  int                m_t [LINES];
  logic [DATA_W-1:0] m_dat [LINES];

  function automatic logic [DATA_W-1:0] initval(int b);
    return (b * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction
  function automatic logic [DATA_W-1:0] mem_rd(int b);
    return mem.exists(b) ? mem[b] : initval(b);
  endfunction
  function automatic logic [DATA_W-1:0] bs_rd(int b);
    return bs.exists(b) ? bs[b] : initval(b);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      wcnt = 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (wcnt == MEM_LAT - 1) begin
        wcnt = 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem[int'(mem_addr)] = mem_wdata;
          nwr++;
        end else begin
          mem_rdata <= mem_rd(int'(mem_addr));
          nrd++;
        end
      end else begin
        wcnt++;
      end
    end
  end

  task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
    end
    $finish;
  endtask

  // Behavioural reference of one access.
  task automatic model(input bit we, input int addr, input logic [DATA_W-1:0] wd,
                       output logic [DATA_W-1:0] erdata, output int erd, output int ewr);
    int blk, idx, tg;
    bit hit;
    blk = addr >> OFS_W; idx = blk % LINES; tg = blk / LINES;
    erd = 0; ewr = 0; erdata = '0;
    if (mode_disable) begin
      if (we) begin bs[blk] = wd; ewr = 1; end
      else begin erdata = bs_rd(blk); erd = 1; end
      return;
    end
    hit = m_v[idx] && (m_t[idx] == tg);
    if (!hit) begin
      if (we && !mode_wb) begin bs[blk] = wd; ewr = 1; return; end
      if (m_v[idx] && m_d[idx]) begin bs[m_t[idx] * LINES + idx] = m_dat[idx]; ewr = 1; end
      erd = 1; m_v[idx] = 1'b1; m_d[idx] = 1'b0; m_t[idx] = tg; m_dat[idx] = bs_rd(blk);
    end
    if (we) begin
      m_dat[idx] = wd;
      if (mode_wb) m_d[idx] = 1'b1;
      else begin bs[blk] = wd; ewr++; end
    end else begin
      erdata = m_dat[idx];
    end
  endtask

  task automatic access(string tag, bit we, int addr, logic [DATA_W-1:0] wd,
                        output logic [DATA_W-1:0] got, output int cyc);
    logic [DATA_W-1:0] erdata;
    int erd, ewr, rd0, wr0;
    model(we, addr, wd, erdata, erd, ewr);
    rd0 = nrd; wr0 = nwr;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr[ADDR_W-1:0]; cpu_wdata = wd;
    #1;
    cyc = 0;
    while (!cpu_ready && cyc < 1000) begin
      @(negedge clk); #1; cyc++;
    end
    got = cpu_rdata;
    if (!cpu_ready) begin
      fails++; tests++;
      $display("FAIL %s access hung actual=%0d expected<1000", tag, cyc);
    end
    @(posedge clk); #1;
    cpu_req = 1'b0; cpu_we = 1'b0;
    if (!we) chk({tag, " rdata"}, got, erdata);
    chk({tag, " mem reads"}, nrd - rd0, erd);
    chk({tag, " mem writes"}, nwr - wr0, ewr);
  endtask

  task automatic command(string tag, bit flush);
    int wr0, rd0, ewr;
    wr0 = nwr; rd0 = nrd; ewr = 0;
    for (int i = 0; i < LINES; i++) begin
      if (flush && m_v[i] && m_d[i]) begin bs[m_t[i] * LINES + i] = m_dat[i]; ewr++; end
      m_v[i] = 1'b0; m_d[i] = 1'b0;
    end
    @(negedge clk);
    if (flush) cmd_flush = 1'b1; else cmd_inval = 1'b1;
    @(negedge clk);
    cmd_flush = 1'b0; cmd_inval = 1'b0;
    repeat (LINES * 6) @(negedge clk);
    chk({tag, " cmd mem writes"}, nwr - wr0, ewr);
    chk({tag, " cmd mem reads"}, nrd - rd0, 0);
  endtask

  function automatic int blk_of(int a);
    return a >> OFS_W;
  endfunction

  localparam int A = 24'h000100, B = A + (LINES << OFS_W), C = 24'h000208;
  localparam int D = 24'h00030C, E = 24'h000410, F = 24'h000514;
  localparam int G = 24'h000618, H = 24'h00071C;

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [DATA_W-1:0] got;
    int cyc;
    for (int i = 0; i < LINES; i++) begin m_v[i] = 1'b0; m_d[i] = 1'b0; m_t[i] = 0; m_dat[i] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R2: idle outputs after reset
    chk("R2 idle cpu_ready", cpu_ready, 1'b0);
    chk("R2 idle mem_req", mem_req, 1'b0);

    // R2 / R4: first read misses, one fill
    access("R4 read miss", 1'b0, A, '0, got, cyc);
    chk("R4 miss stalls", (cyc > 0), 1'b1);
    // R3: hit answers at once
    access("R3 read hit", 1'b0, A, '0, got, cyc);
    chk("R3 hit no wait", cyc, 0);
    // R1: byte offset ignored
    access("R1 offset alias", 1'b0, A + 3, '0, got, cyc);
    chk("R1 alias hit no wait", cyc, 0);

    // R5: write-back store stays in the array
    access("R5 wb write hit", 1'b1, A, 32'hCAFE_0001, got, cyc);
    access("R5 wb read back", 1'b0, A, '0, got, cyc);
    chk("R5 memory untouched", mem_rd(blk_of(A)), initval(blk_of(A)));
    // R6: conflicting read evicts dirty line first
    access("R6 dirty evict", 1'b0, B, '0, got, cyc);
    chk("R6 victim in memory", mem_rd(blk_of(A)), 32'hCAFE_0001);
    access("R6 clean evict", 1'b0, A, '0, got, cyc);
    // R5: write miss allocates by fetching
    access("R5 wb write miss", 1'b1, C, 32'h1234_5678, got, cyc);
    access("R5 alloc read hit", 1'b0, C, '0, got, cyc);
    chk("R5 alloc hit no wait", cyc, 0);

    // R7: write-through
    @(negedge clk); mode_wb = 1'b0;
    access("R7 wt write hit", 1'b1, A, 32'hBEEF_0002, got, cyc);
    chk("R7 memory updated", mem_rd(blk_of(A)), 32'hBEEF_0002);
    access("R7 wt read after write", 1'b0, A, '0, got, cyc);
    access("R7 wt write miss", 1'b1, D, 32'h0D0D_0D0D, got, cyc);
    access("R7 no allocate", 1'b0, D, '0, got, cyc);
    chk("R7 read after no-alloc waited", (cyc > 0), 1'b1);

    // R8: bypass
    @(negedge clk); mode_disable = 1'b1;
    access("R8 bypass read", 1'b0, E, '0, got, cyc);
    access("R8 bypass read again", 1'b0, E, '0, got, cyc);
    access("R8 bypass write", 1'b1, E, 32'hE0E0_E0E0, got, cyc);
    @(negedge clk); mode_disable = 1'b0; mode_wb = 1'b1;
    access("R8 no allocate", 1'b0, E, '0, got, cyc);

    // R9: invalidate discards dirty data
    access("R9 dirty write", 1'b1, F, 32'hF00D_F00D, got, cyc);
    command("R9 inval", 1'b0);
    access("R9 reread misses", 1'b0, F, '0, got, cyc);
    chk("R9 dirty dropped", got, initval(blk_of(F)));

    // R10: flush writes dirty lines then invalidates
    access("R10 dirty G", 1'b1, G, 32'h6666_0006, got, cyc);
    access("R10 dirty H", 1'b1, H, 32'h7777_0007, got, cyc);
    command("R10 flush", 1'b1);
    chk("R10 G in memory", mem_rd(blk_of(G)), 32'h6666_0006);
    chk("R10 H in memory", mem_rd(blk_of(H)), 32'h7777_0007);
    access("R10 reread misses", 1'b0, G, '0, got, cyc);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule